// File: doc/BRIEF.md
# Two-Order Pixel Scanner with Marker Locator

The block walks every pixel of a byte-wide image held in an external synchronous single-port memory, one read per clock. The memory address is the row index joined to the column index rather than a packed linear index. Because of this, image sizes that are not a power of two leave some addresses unused, and the block never has to divide to recover coordinates. A mode input chosen at start selects the traversal order. In row-major order the column counter is the fast counter. In column-major order the row counter is the fast counter. The other counter advances only when the fast one wraps.

The row and column of each read travel with it through a tag pipeline as deep as the memory read latency, so they meet the returned byte. When a returned byte equals the marker value, the block strobes that pixel's coordinates. A "line" is one row in row-major order and one column in column-major order. When the last pixel of a line comes back, the block strobes the line index, a found flag and the midpoint between the first and the last marker seen in that line.

Top module: `marker_scan_top`

## Requirements
- R1: `mem_addr` is `{row[7:0], col[7:0]}`. While `mem_rd_en` is high, the row field is below ROWS (default 240) and the column field is below COLS (default 247).
- R2: In row-major mode (`mode`=0 at start), the column advances by one every read. After COLS-1 the column returns to 0 and the row advances by one.
- R3: In column-major mode (`mode`=1 at start), the row advances by one every read. After ROWS-1 the row returns to 0 and the column advances by one.
- R4: A scan issues exactly ROWS*COLS reads on consecutive cycles. The first read is at (0,0) and appears on the cycle after `start` is sampled.
- R5: A pixel is a marker only when its byte equals 8'hFF; 8'hFE and other values are not markers. For each marker pixel, `mark_valid` pulses with `mark_row`/`mark_col` two cycles after that pixel's address was presented.
- R6: Two cycles after the address of a line's last pixel, `line_valid` pulses. `line_idx` is the row in row-major mode and the column in column-major mode. `line_mid` is (first + last) >> 1, where first and last are the in-line positions of the first and last markers (column in row-major, row in column-major). A line with a single marker gives that marker's position.
- R7: A line with no marker gives `line_found`=0 and `line_mid`=0.
- R8: `start` while a scan runs is ignored, and `mode` is only sampled with an accepted `start`.
- R9: `done` is a one-cycle pulse in the same cycle as the final `line_valid` of a scan. Afterwards `mem_rd_en` stays low until the next `start`.
- R10: After reset, `mem_rd_en`, `mark_valid`, `line_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| mode | input | 1 | 0 row-major, 1 column-major (sampled with start) |
| mem_addr | output | 16 | Read address {row, col} |
| mem_rd_en | output | 1 | Read enable, one read per cycle |
| mem_rdata | input | 8 | Read data, valid RD_LAT cycles after address |
| mark_valid | output | 1 | Marker pixel strobe |
| mark_row | output | 8 | Marker row |
| mark_col | output | 8 | Marker column |
| line_valid | output | 1 | End-of-line strobe |
| line_idx | output | 8 | Index of the finished line |
| line_found | output | 1 | At least one marker in the line |
| line_mid | output | 8 | Midpoint of first and last marker positions |
| done | output | 1 | Scan complete pulse |

## Verification
The bench uses a 5 by 7 image and runs each image pattern in both traversal orders. The patterns are:
- An image with no markers, which isolates the not-found path.
- An image of all markers, where every midpoint is the line centre.
- A diagonal stripe and a sparse modular pattern, which give lines whose first and last markers differ and lines with a single marker.
- A lone marker surrounded by 8'hFE, which separates an exact match from a near match.

The bench checks every address and every output cycle by cycle against a scan order it derives itself. Running each pattern in both orders shows whether the fast counter, the line index and the in-line position swap correctly. A start pulse and a mode flip in the middle of a scan show whether a running scan is disturbed.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
  localparam int COORD_W = 8;
  localparam int ADDR_W  = 2 * COORD_W;

  typedef logic [COORD_W-1:0] coord_t;

  // tag carried alongside each memory read
  typedef struct packed {
    logic   vld;   // a read was issued for this slot
    logic   eol;   // last pixel of its line
    logic   fin;   // last pixel of the scan
    logic   cmaj;  // column-major traversal
    coord_t row;
    coord_t col;
  } tag_t;

  // advance a coordinate, wrapping to zero after lim
  function automatic coord_t wrap_inc(coord_t v, coord_t lim);
    return (v == lim) ? '0 : v + coord_t'(1);
  endfunction

  // floor of the mean of two positions, without overflow
  function automatic coord_t mid_of(coord_t a, coord_t b);
    logic [COORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[COORD_W:1];
  endfunction
endpackage

// File: rtl/mscan_addr_gen.sv
module mscan_addr_gen
  import mscan_pkg::*;
#(
  parameter int ROWS = 240,
  parameter int COLS = 247
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   mode,
  output logic   busy,
  output logic   cmaj,
  output coord_t row,
  output coord_t col,
  output logic   eol,
  output logic   fin
);
  localparam coord_t RMAX = coord_t'(ROWS - 1);
  localparam coord_t CMAX = coord_t'(COLS - 1);

  logic   row_top, col_top;
  coord_t row_n, col_n;

  assign row_top = (row == RMAX);
  assign col_top = (col == CMAX);
  assign fin     = row_top && col_top;
  assign eol     = cmaj ? row_top : col_top;

  always_comb begin
    if (cmaj) begin
      row_n = wrap_inc(row, RMAX);
      col_n = row_top ? wrap_inc(col, CMAX) : col;
    end else begin
      col_n = wrap_inc(col, CMAX);
      row_n = col_top ? wrap_inc(row, RMAX) : row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cmaj <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cmaj <= mode;
      row  <= '0;
      col  <= '0;
    end else if (busy) begin
      row <= row_n;
      col <= col_n;
      if (fin) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mscan_tag_pipe.sv
module mscan_tag_pipe
  import mscan_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  tag_t tag_in,
  output tag_t tag_out
);
  localparam int DEPTH = (RD_LAT < 1) ? 1 : RD_LAT;

  tag_t stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= tag_in;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign tag_out = stage[DEPTH-1];
endmodule

// File: rtl/mscan_line_trk.sv
module mscan_line_trk
  import mscan_pkg::*;
#(
  parameter logic [7:0] MARKER = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tag_t       tag,
  input  logic [7:0] rdata,
  output logic       hit,
  output logic       mark_valid,
  output coord_t     mark_row,
  output coord_t     mark_col,
  output logic       line_valid,
  output coord_t     line_idx,
  output logic       line_found,
  output coord_t     line_mid,
  output logic       done
);
  coord_t pos, line, first_q, last_q, first_n, last_n;
  logic   have_q, found_n;

  assign hit     = tag.vld && (rdata == MARKER);
  assign pos     = tag.cmaj ? tag.row : tag.col;
  assign line    = tag.cmaj ? tag.col : tag.row;
  assign found_n = have_q || hit;
  assign first_n = have_q ? first_q : pos;
  assign last_n  = hit ? pos : last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      first_q    <= '0;
      last_q     <= '0;
      mark_valid <= 1'b0;
      mark_row   <= '0;
      mark_col   <= '0;
      line_valid <= 1'b0;
      line_idx   <= '0;
      line_found <= 1'b0;
      line_mid   <= '0;
      done       <= 1'b0;
    end else begin
      mark_valid <= hit;
      line_valid <= tag.vld && tag.eol;
      done       <= tag.vld && tag.fin;
      if (hit) begin
        mark_row <= tag.row;
        mark_col <= tag.col;
      end
      if (tag.vld) begin
        if (tag.eol) begin
          line_idx   <= line;
          line_found <= found_n;
          line_mid   <= found_n ? mid_of(first_n, last_n) : '0;
          have_q     <= 1'b0;
        end else if (hit) begin
          have_q  <= 1'b1;
          first_q <= first_n;
          last_q  <= pos;
        end
      end
    end
  end
endmodule

// File: rtl/marker_scan_top.sv
module marker_scan_top
  import mscan_pkg::*;
#(
  parameter int         ROWS   = 240,
  parameter int         COLS   = 247,
  parameter int         RD_LAT = 1,
  parameter logic [7:0] MARKER = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode,
  output logic [15:0] mem_addr,
  output logic        mem_rd_en,
  input  logic [7:0]  mem_rdata,
  output logic        mark_valid,
  output logic [7:0]  mark_row,
  output logic [7:0]  mark_col,
  output logic        line_valid,
  output logic [7:0]  line_idx,
  output logic        line_found,
  output logic [7:0]  line_mid,
  output logic        done
);
  // named internal events for the checker
  logic   scan_busy, scan_cmaj, issue_eol, issue_fin, pix_hit;
  coord_t cur_row, cur_col;
  tag_t   issue_tag, data_tag;

  mscan_addr_gen #(.ROWS(ROWS), .COLS(COLS)) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .mode  (mode),
    .busy  (scan_busy),
    .cmaj  (scan_cmaj),
    .row   (cur_row),
    .col   (cur_col),
    .eol   (issue_eol),
    .fin   (issue_fin)
  );

  assign mem_addr  = {cur_row, cur_col};
  assign mem_rd_en = scan_busy;

  always_comb begin
    issue_tag      = '0;
    issue_tag.vld  = scan_busy;
    issue_tag.eol  = issue_eol;
    issue_tag.fin  = issue_fin;
    issue_tag.cmaj = scan_cmaj;
    issue_tag.row  = cur_row;
    issue_tag.col  = cur_col;
  end

  mscan_tag_pipe #(.RD_LAT(RD_LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_in  (issue_tag),
    .tag_out (data_tag)
  );

  mscan_line_trk #(.MARKER(MARKER)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag        (data_tag),
    .rdata      (mem_rdata),
    .hit        (pix_hit),
    .mark_valid (mark_valid),
    .mark_row   (mark_row),
    .mark_col   (mark_col),
    .line_valid (line_valid),
    .line_idx   (line_idx),
    .line_found (line_found),
    .line_mid   (line_mid),
    .done       (done)
  );
endmodule

// File: rtl/marker_scan_chk.sv
module marker_scan_chk #(
  parameter int ROWS = 240,
  parameter int COLS = 247
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        scan_cmaj,
  input logic [15:0] mem_addr,
  input logic        mem_rd_en,
  input logic [7:0]  mem_rdata,
  input logic        mark_valid,
  input logic [7:0]  mark_row,
  input logic [7:0]  mark_col,
  input logic        line_valid,
  input logic        line_found,
  input logic [7:0]  line_mid,
  input logic        done
);
  localparam logic [7:0] RMAX = 8'(ROWS - 1);
  localparam logic [7:0] CMAX = 8'(COLS - 1);

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[15:8] <= RMAX && mem_addr[7:0] <= CMAX));

  // R2
  row_major_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !scan_cmaj && mem_addr[7:0] != CMAX) |=>
      (mem_rd_en && mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1
                 && mem_addr[15:8] == $past(mem_addr[15:8])));

  // R3
  col_major_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && scan_cmaj && mem_addr[15:8] != RMAX) |=>
      (mem_rd_en && mem_addr[15:8] == $past(mem_addr[15:8]) + 8'd1
                 && mem_addr[7:0] == $past(mem_addr[7:0])));

  // R4
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |-> mem_addr == 16'h0000);

  // R5
  marker_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> $past(mem_rdata) == 8'hFF);

  // R5
  marker_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> {mark_row, mark_col} == $past(mem_addr, 2));

  // R7
  empty_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_found) |-> line_mid == 8'd0);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (line_valid && !mem_rd_en) ##1 !done);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd_en) && mem_rd_en) |-> $stable(scan_cmaj));
endmodule

bind marker_scan_top marker_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .scan_cmaj  (scan_cmaj),
  .mem_addr   (mem_addr),
  .mem_rd_en  (mem_rd_en),
  .mem_rdata  (mem_rdata),
  .mark_valid (mark_valid),
  .mark_row   (mark_row),
  .mark_col   (mark_col),
  .line_valid (line_valid),
  .line_found (line_found),
  .line_mid   (line_mid),
  .done       (done)
);

// File: tb/marker_scan_top_tb.sv
module marker_scan_top_tb;
  localparam int RWS = 5;
  localparam int CLS = 7;
  localparam int N   = RWS * CLS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mark_valid, line_valid, line_found, done;
  logic [7:0]  mark_row, mark_col, line_idx, line_mid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int cur_pat = 0;

  always #5 clk = ~clk;

  marker_scan_top #(.ROWS(RWS), .COLS(CLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mark_valid(mark_valid), .mark_row(mark_row), .mark_col(mark_col),
    .line_valid(line_valid), .line_idx(line_idx), .line_found(line_found),
    .line_mid(line_mid), .done(done)
  );

  function automatic logic [7:0] pix(int pat, int r, int c);
    case (pat)
      0: return 8'h10;
      1: return ((r + c) % 3 == 0) ? 8'hFF : 8'hFE;
      2: return ((r * 3 + c * 5) % 7 == 0) ? 8'hFF : 8'h7F;
      3: return 8'hFF;
      4: return (r == 2 && c == 4) ? 8'hFF : 8'hFE;
      default: return 8'h00;
    endcase
  endfunction

  // memory model: one-cycle synchronous read
  always @(posedge clk)
    if (mem_rd_en) mem_rdata <= pix(cur_pat, int'(mem_addr[15:8]), int'(mem_addr[7:0]));

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // scan-order coordinate of pixel k
  function automatic void coord(int cm, int k, output int r, output int c);
    if (cm != 0) begin c = k / RWS; r = k % RWS; end
    else         begin r = k / CLS; c = k % CLS; end
  endfunction

  function automatic void line_exp(int pat, int cm, int ln, output int fnd, output int mid);
    int npos, first, last;
    npos = (cm != 0) ? RWS : CLS;
    fnd = 0; first = 0; last = 0;
    for (int p = 0; p < npos; p++) begin
      if (pix(pat, (cm != 0) ? p : ln, (cm != 0) ? ln : p) == 8'hFF) begin
        if (fnd == 0) first = p;
        last = p;
        fnd = 1;
      end
    end
    mid = (fnd != 0) ? (first + last) / 2 : 0;
  endfunction

  task automatic run_scan(int cm, int pat, bit glitch);
    int addr_err, done_err, r, c, fnd, mid, k, fast, fmax;
    bit em, el;
    addr_err = 0; done_err = 0;
    cur_pat = pat;
    @(negedge clk);
    mode = cm[0]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int m = 0; m < N + 5; m++) begin
      if (glitch && m == 9)  begin start = 1'b1; mode = ~cm[0]; end
      if (glitch && m == 10) begin start = 1'b0; mode = cm[0]; end
      // R1 R2 R3 R4: address and enable
      if (m < N) begin
        coord(cm, m, r, c);
        if (!mem_rd_en || mem_addr != {8'(r), 8'(c)}) addr_err++;
      end else if (mem_rd_en) addr_err++;
      k = m - 2;
      em = 0; el = 0;
      if (k >= 0 && k < N) begin
        coord(cm, k, r, c);
        em = (pix(pat, r, c) == 8'hFF);
        fast = (cm != 0) ? r : c;
        fmax = (cm != 0) ? RWS - 1 : CLS - 1;
        el = (fast == fmax);
      end
      // R5 marker strobe
      if (em || mark_valid) begin
        tests++;
        if (mark_valid != em || (em && (int'(mark_row) != r || int'(mark_col) != c))) begin
          fails++;
          $display("FAIL R5 mode=%0d pat=%0d k=%0d: actual v=%0d (%0d,%0d) expected v=%0d (%0d,%0d)",
                   cm, pat, k, mark_valid, mark_row, mark_col, em, r, c);
        end
      end
      // R6 R7 line result
      if (el || line_valid) begin
        tests++;
        if (el) line_exp(pat, cm, (cm != 0) ? c : r, fnd, mid);
        if (line_valid != el || (el && (int'(line_idx) != ((cm != 0) ? c : r)
            || int'(line_found) != fnd || int'(line_mid) != mid))) begin
          fails++;
          $display("FAIL R6/R7 mode=%0d pat=%0d k=%0d: actual v=%0d idx=%0d f=%0d mid=%0d expected v=%0d idx=%0d f=%0d mid=%0d",
                   cm, pat, k, line_valid, line_idx, line_found, line_mid,
                   el, (cm != 0) ? c : r, fnd, mid);
        end
      end
      // R9 done timing
      if (done != (k == N - 1)) done_err++;
      @(negedge clk);
    end
    tests++;
    if (addr_err != 0) begin
      fails++;
      $display("FAIL R4 mode=%0d pat=%0d address sequence: actual %0d mismatches expected 0", cm, pat, addr_err);
    end
    tests++;
    if (done_err != 0) begin
      fails++;
      $display("FAIL R9 mode=%0d pat=%0d done timing: actual %0d mismatches expected 0", cm, pat, done_err);
    end
  endtask

  // {mode, pattern}
  localparam logic [3:0] VEC [8] = '{
    4'b0_000, 4'b1_000, 4'b0_001, 4'b1_001,
    4'b0_010, 4'b1_010, 4'b0_011, 4'b1_011
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    tests++;
    if (mem_rd_en || mark_valid || line_valid || done) begin
      fails++;
      $display("FAIL R10 in reset: actual rd=%0d mk=%0d ln=%0d dn=%0d expected all 0",
               mem_rd_en, mark_valid, line_valid, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (mem_rd_en || mark_valid || line_valid || done) begin
      fails++;
      $display("FAIL R10 after reset: actual rd=%0d mk=%0d ln=%0d dn=%0d expected all 0",
               mem_rd_en, mark_valid, line_valid, done);
    end
    // table of patterns in both orders: R2 R3 R5 R6 R7
    for (int i = 0; i < 8; i++) run_scan(int'(VEC[i][3]), int'(VEC[i][2:0]), 1'b0);
    // lone marker, near-values 8'hFE elsewhere: R5 R6
    run_scan(0, 4, 1'b0);
    run_scan(1, 4, 1'b0);
    // start and mode flip while busy: R8
    run_scan(0, 1, 1'b1);
    run_scan(1, 2, 1'b1);
    // idle after done: R9
    repeat (4) @(negedge clk);
    tests++;
    if (mem_rd_en || done) begin
      fails++;
      $display("FAIL R9 idle: actual rd=%0d dn=%0d expected 0 0", mem_rd_en, done);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule